// File: doc/BRIEF.md
# Inclusive L2 Snoop Filter

This block holds the coherence tags and states of a second-level cache that contains everything in the private first-level (L1) write-back cache above it. Because of that containment, only this level watches the shared bus. Each L2 line carries two extra flags. One records that the L1 also holds the line. The other records that the L1 has written the line, so the L2 copy of the data is out of date. With these flags the block can drop snoops that do not concern the L1. It sends invalidate or downgrade commands to the L1 only when the L1 holds the line, and it pulls the current data up from the L1 before it puts a line on the bus.

The L1 side sends fill, write-hit and eviction notices on one valid/ready port. The bus side sends snoops (plain read or read-for-ownership) on a second valid/ready port. The block handles one operation at a time. It may emit a command to the L1, wait for data the L1 returns, then put a line onto the bus through a flush stream. A fill into a set that holds a different line displaces that line, and the same steps keep inclusion. Every handshake completes on a clock edge where valid and ready are both high. The block keeps each offered item (command or flush) stable until it is taken, and while an operation is in progress it holds both request ports not-ready.

Top module: `l2_snoop_filter`

## Requirements
- R1: After reset every line is invalid, both request ports are ready, and no L1 command or flush is offered.
- R2: A fill (up_op=0) of an absent line installs it with up_data, marks it held by L1 and not stale, and sets the state to Modified if up_wr=1, else Exclusive if up_excl=1, else Shared. A fill that hits only marks the line held by L1 and, if up_wr=1, makes it Modified.
- R3: A read-for-ownership snoop (snp_rdx=1) that hits a line held by L1 sends an L1 command with dn_inv=1 (dn_fetch=1 when the line is stale) and leaves the line invalid.
- R4: A snoop that misses in L2 sends nothing to the L1 and flushes nothing.
- R5: A write-hit notice (up_op=1) to a line held by L1 in Exclusive or Modified makes it Modified and stale. A write-hit notice to a Shared or absent line has no effect.
- R6: A plain read snoop (snp_rdx=0) that hits a stale Modified line first sends dn_inv=0, dn_fetch=1, then flushes the data returned on rt_data, and leaves the line Shared and not stale.
- R7: A plain read snoop that hits a Modified line that is not stale flushes the L2 data. When it hits Exclusive or Modified while the L1 holds the line, it sends a downgrade (dn_inv=0, dn_fetch=0). The line ends Shared. A read snoop to a Shared line does nothing.
- R8: A read-for-ownership snoop that hits a Modified line flushes it, using the L1 data when the line is stale.
- R9: An eviction notice (up_op=2) clears the held-by-L1 flag. With up_dirty=1 it also stores up_data and clears the stale flag.
- R10: A fill into a set that holds a different valid line displaces that line. The block invalidates the L1 copy if one exists (fetching it if stale), then flushes the victim if it was Modified.
- R11: When a snoop and an L1 notice are both offered to an idle block, the snoop is taken first.
- R12: dn_valid and fl_valid, with their payloads, stay unchanged until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | L1 notice offered |
| up_ready | output | 1 | L1 notice accepted this cycle when valid |
| up_op | input | 2 | 0 fill, 1 write hit, 2 eviction |
| up_addr | input | ADDR_W | Line address of the notice |
| up_wr | input | 1 | Fill is for a write (ownership already obtained) |
| up_excl | input | 1 | Fill found no other sharer |
| up_dirty | input | 1 | Eviction carries written-back data |
| up_data | input | LINE_W | Fill data or written-back data |
| snp_valid | input | 1 | Bus snoop offered |
| snp_ready | output | 1 | Snoop accepted this cycle when valid |
| snp_rdx | input | 1 | 1 read-for-ownership, 0 plain read |
| snp_addr | input | ADDR_W | Snooped line address |
| dn_valid | output | 1 | Command to L1 offered |
| dn_ready | input | 1 | L1 takes the command |
| dn_addr | output | ADDR_W | Line the command refers to |
| dn_inv | output | 1 | 1 invalidate, 0 downgrade to shared |
| dn_fetch | output | 1 | L1 must return its data on the return port |
| rt_valid | input | 1 | L1 data return offered |
| rt_ready | output | 1 | Block takes the return |
| rt_data | input | LINE_W | Line data returned by L1 |
| fl_valid | output | 1 | Line flush onto the bus offered |
| fl_ready | input | 1 | Bus takes the flush |
| fl_addr | output | ADDR_W | Flushed line address |
| fl_data | output | LINE_W | Flushed line data |

## Verification
The bench goes after the flag corner cases. A stale line hit by a plain read must fetch before flushing; a design that skips this flushes old memory data and the data compare catches it. A line the L1 has evicted must not draw an invalidate, and a write-hit notice to a Shared line must be ignored; a design that gets either wrong shows an extra command or flush on a later snoop. A displacing fill must invalidate and write back the victim; a design that skips it leaves inclusion broken and the expected victim flush never appears. The bench also offers a snoop and a notice in the same cycle, where taking the notice first would turn a clean flush into a fetch, and it holds the bus not-ready to confirm the flush stays stable.

// File: rtl/l2sf_pkg.sv
package l2sf_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } cstate_e;

  typedef enum logic [1:0] {
    UP_FILL  = 2'd0,
    UP_WRHIT = 2'd1,
    UP_EVICT = 2'd2,
    UP_NONE  = 2'd3
  } upop_e;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_DN   = 3'd1,
    SQ_RT   = 3'd2,
    SQ_FL   = 3'd3,
    SQ_WR   = 3'd4
  } seq_e;
endpackage

// File: rtl/l2sf_dir.sv
module l2sf_dir
  import l2sf_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int TAG_W  = 9,
  parameter int LINE_W = 32,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  output cstate_e           rd_st,
  output logic              rd_inl1,
  output logic              rd_mbs,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_dat,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  cstate_e           wr_st,
  input  logic              wr_inl1,
  input  logic              wr_mbs,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_dat
);
  cstate_e           st_q   [SETS];
  logic              inl1_q [SETS];
  logic              mbs_q  [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] dat_q  [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic hit_wr;
    assign hit_wr = wr_en && (wr_set == SET_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= ST_I;
        inl1_q[g] <= 1'b0;
        mbs_q[g]  <= 1'b0;
      end else if (hit_wr) begin
        st_q[g]   <= wr_st;
        inl1_q[g] <= wr_inl1;
        mbs_q[g]  <= wr_mbs;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_wr) begin
        tag_q[g] <= wr_tag;
        dat_q[g] <= wr_dat;
      end
    end
  end

  assign rd_st   = st_q[rd_set];
  assign rd_inl1 = inl1_q[rd_set];
  assign rd_mbs  = mbs_q[rd_set];
  assign rd_tag  = tag_q[rd_set];
  assign rd_dat  = dat_q[rd_set];

  // R5: a stale line is always owned in L2 and held by L1
  a_r5_stale_is_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mbs) |-> (wr_st == ST_M && wr_inl1));

  // R2: a line marked as held by L1 is never invalid in L2 (inclusion)
  a_r2_inclusion: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_inl1) |-> (wr_st != ST_I));
endmodule

// File: rtl/l2sf_intake.sv
module l2sf_intake
  import l2sf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LINE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic              snp_rdx,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [1:0]        up_op,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_wr,
  input  logic              up_excl,
  input  logic              up_dirty,
  input  logic [LINE_W-1:0] up_data,
  input  logic              op_done,
  output logic              op_valid,
  output logic              op_snp,
  output logic              op_rdx,
  output upop_e             op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic              op_wr,
  output logic              op_excl,
  output logic              op_dirty,
  output logic [LINE_W-1:0] op_data
);
  logic take_snp, take_up;

  assign snp_ready = !op_valid;
  assign up_ready  = !op_valid && !snp_valid;
  assign take_snp  = snp_valid && snp_ready;
  assign take_up   = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_snp   <= 1'b0;
      op_rdx   <= 1'b0;
      op_kind  <= UP_NONE;
      op_addr  <= '0;
      op_wr    <= 1'b0;
      op_excl  <= 1'b0;
      op_dirty <= 1'b0;
      op_data  <= '0;
    end else if (op_done) begin
      op_valid <= 1'b0;
    end else if (take_snp) begin
      op_valid <= 1'b1;
      op_snp   <= 1'b1;
      op_rdx   <= snp_rdx;
      op_kind  <= UP_NONE;
      op_addr  <= snp_addr;
      op_wr    <= 1'b0;
      op_excl  <= 1'b0;
      op_dirty <= 1'b0;
    end else if (take_up) begin
      op_valid <= 1'b1;
      op_snp   <= 1'b0;
      op_rdx   <= 1'b0;
      op_kind  <= upop_e'(up_op);
      op_addr  <= up_addr;
      op_wr    <= up_wr;
      op_excl  <= up_excl;
      op_dirty <= up_dirty;
      op_data  <= up_data;
    end
  end

  // R11: with both requests offered to an idle block, the snoop is the one captured
  a_r11_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && snp_valid && up_valid) |=> (op_valid && op_snp));

  // R12: no second operation is captured while one is pending
  a_r12_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_done) |=> (op_valid && $stable(op_addr)));
endmodule

// File: rtl/l2sf_seq.sv
module l2sf_seq
  import l2sf_pkg::*;
#(
  parameter int SET_W  = 3,
  parameter int TAG_W  = 9,
  parameter int LINE_W = 32,
  localparam int ADDR_W = SET_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_snp,
  input  logic              op_rdx,
  input  upop_e             op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_wr,
  input  logic              op_excl,
  input  logic              op_dirty,
  input  logic [LINE_W-1:0] op_data,
  output logic              op_done,
  output logic [SET_W-1:0]  rd_set,
  input  cstate_e           rd_st,
  input  logic              rd_inl1,
  input  logic              rd_mbs,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [LINE_W-1:0] rd_dat,
  output logic              wr_en,
  output logic [SET_W-1:0]  wr_set,
  output cstate_e           wr_st,
  output logic              wr_inl1,
  output logic              wr_mbs,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [LINE_W-1:0] wr_dat,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_inv,
  output logic              dn_fetch,
  input  logic              rt_valid,
  output logic              rt_ready,
  input  logic [LINE_W-1:0] rt_data,
  output logic              fl_valid,
  input  logic              fl_ready,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [LINE_W-1:0] fl_data
);
  seq_e sq;

  logic [SET_W-1:0] op_set;
  logic [TAG_W-1:0] op_tag;
  logic             hit;
  logic             owned;
  assign op_set = op_addr[SET_W-1:0];
  assign op_tag = op_addr[ADDR_W-1:SET_W];
  assign rd_set = op_set;
  assign hit    = (rd_st != ST_I) && (rd_tag == op_tag);
  assign owned  = (rd_st == ST_E) || (rd_st == ST_M);

  // plan of the current operation, decided from the looked-up line
  logic              ev_dn, ev_inv, ev_fetch, ev_fl;
  logic [ADDR_W-1:0] ev_addr;

  always_comb begin
    ev_dn    = 1'b0;
    ev_inv   = 1'b0;
    ev_fetch = 1'b0;
    ev_fl    = 1'b0;
    ev_addr  = op_addr;
    if (op_snp) begin
      if (hit) begin
        if (op_rdx) begin
          ev_dn    = rd_inl1;
          ev_inv   = 1'b1;
          ev_fetch = rd_inl1 && rd_mbs;
          ev_fl    = (rd_st == ST_M);
        end else if (owned) begin
          ev_dn    = rd_inl1;
          ev_inv   = 1'b0;
          ev_fetch = rd_inl1 && rd_mbs;
          ev_fl    = (rd_st == ST_M);
        end
      end
    end else if (op_kind == UP_FILL && !hit && rd_st != ST_I) begin
      ev_addr  = {rd_tag, op_set};
      ev_dn    = rd_inl1;
      ev_inv   = 1'b1;
      ev_fetch = rd_inl1 && rd_mbs;
      ev_fl    = (rd_st == ST_M);
    end
  end

  logic              hit_q, fl_q, fetch_q;
  cstate_e           e_st_q;
  logic              e_inl1_q, e_mbs_q;
  logic [TAG_W-1:0]  e_tag_q;
  logic [LINE_W-1:0] e_dat_q, buf_q;
  logic [ADDR_W-1:0] dn_addr_q, fl_addr_q;
  logic              dn_inv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq        <= SQ_IDLE;
      hit_q     <= 1'b0;
      fl_q      <= 1'b0;
      fetch_q   <= 1'b0;
      dn_inv_q  <= 1'b0;
      dn_addr_q <= '0;
      fl_addr_q <= '0;
      e_st_q    <= ST_I;
      e_inl1_q  <= 1'b0;
      e_mbs_q   <= 1'b0;
      e_tag_q   <= '0;
      e_dat_q   <= '0;
      buf_q     <= '0;
    end else begin
      unique case (sq)
        SQ_IDLE: if (op_valid) begin
          hit_q     <= hit;
          fl_q      <= ev_fl;
          fetch_q   <= ev_fetch;
          dn_inv_q  <= ev_inv;
          dn_addr_q <= ev_addr;
          fl_addr_q <= ev_addr;
          e_st_q    <= rd_st;
          e_inl1_q  <= rd_inl1;
          e_mbs_q   <= rd_mbs;
          e_tag_q   <= rd_tag;
          e_dat_q   <= rd_dat;
          if (ev_dn)      sq <= SQ_DN;
          else if (ev_fl) sq <= SQ_FL;
          else            sq <= SQ_WR;
        end
        SQ_DN: if (dn_ready) begin
          if (fetch_q)   sq <= SQ_RT;
          else if (fl_q) sq <= SQ_FL;
          else           sq <= SQ_WR;
        end
        SQ_RT: if (rt_valid) begin
          buf_q <= rt_data;
          sq    <= fl_q ? SQ_FL : SQ_WR;
        end
        SQ_FL: if (fl_ready) sq <= SQ_WR;
        SQ_WR: sq <= SQ_IDLE;
        default: sq <= SQ_IDLE;
      endcase
    end
  end

  assign dn_valid = (sq == SQ_DN);
  assign dn_addr  = dn_addr_q;
  assign dn_inv   = dn_inv_q;
  assign dn_fetch = fetch_q;
  assign rt_ready = (sq == SQ_RT);
  assign fl_valid = (sq == SQ_FL);
  assign fl_addr  = fl_addr_q;
  assign fl_data  = fetch_q ? buf_q : e_dat_q;
  assign op_done  = (sq == SQ_WR);

  // final line contents once every transfer has completed
  logic upd;
  always_comb begin
    upd     = 1'b0;
    wr_st   = e_st_q;
    wr_inl1 = e_inl1_q;
    wr_mbs  = e_mbs_q;
    wr_tag  = e_tag_q;
    wr_dat  = e_dat_q;
    if (op_snp) begin
      upd = hit_q;
      if (op_rdx) begin
        wr_st   = ST_I;
        wr_inl1 = 1'b0;
        wr_mbs  = 1'b0;
      end else begin
        if (e_st_q == ST_E || e_st_q == ST_M) wr_st = ST_S;
        wr_mbs = 1'b0;
        if (fetch_q) wr_dat = buf_q;
      end
    end else begin
      unique case (op_kind)
        UP_FILL: begin
          upd     = 1'b1;
          wr_inl1 = 1'b1;
          if (hit_q) begin
            if (op_wr) wr_st = ST_M;
          end else begin
            wr_tag = op_tag;
            wr_dat = op_data;
            wr_mbs = 1'b0;
            wr_st  = op_wr ? ST_M : (op_excl ? ST_E : ST_S);
          end
        end
        UP_WRHIT: begin
          if (hit_q && e_inl1_q && (e_st_q == ST_E || e_st_q == ST_M)) begin
            upd    = 1'b1;
            wr_st  = ST_M;
            wr_mbs = 1'b1;
          end
        end
        UP_EVICT: begin
          if (hit_q) begin
            upd     = 1'b1;
            wr_inl1 = 1'b0;
            if (op_dirty) begin
              wr_mbs = 1'b0;
              wr_dat = op_data;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_en  = (sq == SQ_WR) && upd;
  assign wr_set = op_set;

  // R12: an offered L1 command holds until taken
  a_r12_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_inv) && $stable(dn_fetch)));

  // R12: an offered flush holds until taken
  a_r12_fl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !fl_ready) |=> (fl_valid && $stable(fl_addr) && $stable(fl_data)));

  // R4: a snoop that misses produces no L1 command and no flush
  a_r4_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sq == SQ_IDLE && op_valid && op_snp && !hit) |=> (!dn_valid && !fl_valid));

  // R6: returned data is only accepted after a fetching command was taken
  a_r6_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rt_ready) |-> ($past(dn_valid) && $past(dn_ready) && dn_fetch));
endmodule

// File: rtl/l2_snoop_filter.sv
module l2_snoop_filter
  import l2sf_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int ADDR_W = 12,
  parameter int LINE_W = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [1:0]        up_op,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_wr,
  input  logic              up_excl,
  input  logic              up_dirty,
  input  logic [LINE_W-1:0] up_data,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic              snp_rdx,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_inv,
  output logic              dn_fetch,
  input  logic              rt_valid,
  output logic              rt_ready,
  input  logic [LINE_W-1:0] rt_data,
  output logic              fl_valid,
  input  logic              fl_ready,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [LINE_W-1:0] fl_data
);
  logic              op_valid, op_snp, op_rdx, op_wr, op_excl, op_dirty, op_done;
  upop_e             op_kind;
  logic [ADDR_W-1:0] op_addr;
  logic [LINE_W-1:0] op_data;

  logic [SET_W-1:0]  rd_set, wr_set;
  cstate_e           rd_st, wr_st;
  logic              rd_inl1, rd_mbs, wr_en, wr_inl1, wr_mbs;
  logic [TAG_W-1:0]  rd_tag, wr_tag;
  logic [LINE_W-1:0] rd_dat, wr_dat;

  l2sf_intake #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_intake (
    .clk, .rst_n,
    .snp_valid, .snp_ready, .snp_rdx, .snp_addr,
    .up_valid, .up_ready, .up_op, .up_addr, .up_wr, .up_excl, .up_dirty, .up_data,
    .op_done, .op_valid, .op_snp, .op_rdx, .op_kind, .op_addr,
    .op_wr, .op_excl, .op_dirty, .op_data
  );

  l2sf_dir #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_dir (
    .clk, .rst_n,
    .rd_set, .rd_st, .rd_inl1, .rd_mbs, .rd_tag, .rd_dat,
    .wr_en, .wr_set, .wr_st, .wr_inl1, .wr_mbs, .wr_tag, .wr_dat
  );

  l2sf_seq #(.SET_W(SET_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_seq (
    .clk, .rst_n,
    .op_valid, .op_snp, .op_rdx, .op_kind, .op_addr, .op_wr, .op_excl,
    .op_dirty, .op_data, .op_done,
    .rd_set, .rd_st, .rd_inl1, .rd_mbs, .rd_tag, .rd_dat,
    .wr_en, .wr_set, .wr_st, .wr_inl1, .wr_mbs, .wr_tag, .wr_dat,
    .dn_valid, .dn_ready, .dn_addr, .dn_inv, .dn_fetch,
    .rt_valid, .rt_ready, .rt_data,
    .fl_valid, .fl_ready, .fl_addr, .fl_data
  );
endmodule

// File: tb/l2_snoop_filter_tb.sv
module l2_snoop_filter_tb;
  localparam int ADDR_W = 12;
  localparam int LINE_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              up_valid = 1'b0, up_ready;
  logic [1:0]        up_op = 2'd0;
  logic [ADDR_W-1:0] up_addr = '0;
  logic              up_wr = 1'b0, up_excl = 1'b0, up_dirty = 1'b0;
  logic [LINE_W-1:0] up_data = '0;
  logic              snp_valid = 1'b0, snp_ready, snp_rdx = 1'b0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic              dn_valid, dn_ready = 1'b0, dn_inv, dn_fetch;
  logic [ADDR_W-1:0] dn_addr;
  logic              rt_valid = 1'b0, rt_ready;
  logic [LINE_W-1:0] rt_data = '0;
  logic              fl_valid, fl_ready = 1'b0;
  logic [ADDR_W-1:0] fl_addr;
  logic [LINE_W-1:0] fl_data;

  l2_snoop_filter u_dut (
    .clk, .rst_n,
    .up_valid, .up_ready, .up_op, .up_addr, .up_wr, .up_excl, .up_dirty, .up_data,
    .snp_valid, .snp_ready, .snp_rdx, .snp_addr,
    .dn_valid, .dn_ready, .dn_addr, .dn_inv, .dn_fetch,
    .rt_valid, .rt_ready, .rt_data,
    .fl_valid, .fl_ready, .fl_addr, .fl_data
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit hold_fl = 1'b0;

  logic [ADDR_W+1:0]        exp_dn [$];
  string                    dn_tag [$];
  logic [ADDR_W+LINE_W-1:0] exp_fl [$];
  string                    fl_tag [$];

  function automatic logic [LINE_W-1:0] l1val(logic [ADDR_W-1:0] a);
    return 32'hC0DE_0000 ^ {20'h0, a};
  endfunction
  function automatic logic [LINE_W-1:0] memval(logic [ADDR_W-1:0] a);
    return 32'h1000_0000 | {20'h0, a};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic want_dn(logic [ADDR_W-1:0] a, bit inv, bit fetch, string req);
    exp_dn.push_back({a, inv, fetch});
    dn_tag.push_back(req);
  endtask
  task automatic want_fl(logic [ADDR_W-1:0] a, logic [LINE_W-1:0] d, string req);
    exp_fl.push_back({a, d});
    fl_tag.push_back(req);
  endtask

  // ready pattern for back-pressure
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    #1;
    lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    dn_ready = (lfsr[1:0] != 2'b00);
    fl_ready = !hold_fl && (lfsr[3:2] != 2'b00);
  end

  // monitor: L1 commands
  always @(negedge clk) begin
    if (rst_n && dn_valid && dn_ready) begin
      if (exp_dn.size() == 0)
        chk(1'b0, "R4", "unexpected L1 command", {dn_addr, dn_inv, dn_fetch}, 0);
      else begin
        logic [ADDR_W+1:0] e;
        string t;
        e = exp_dn.pop_front();
        t = dn_tag.pop_front();
        chk({dn_addr, dn_inv, dn_fetch} == e, t, "L1 command {addr,inv,fetch}",
            {dn_addr, dn_inv, dn_fetch}, e);
      end
    end
  end

  // monitor: bus flushes, plus hold check
  logic              fl_prev_stall = 1'b0;
  logic [ADDR_W+LINE_W-1:0] fl_prev = '0;
  always @(negedge clk) begin
    if (rst_n && fl_prev_stall)
      chk(fl_valid && ({fl_addr, fl_data} == fl_prev), "R12", "flush held under stall",
          {fl_valid, fl_addr, fl_data}, {1'b1, fl_prev});
    fl_prev_stall = rst_n && fl_valid && !fl_ready;
    fl_prev       = {fl_addr, fl_data};
    if (rst_n && fl_valid && fl_ready) begin
      if (exp_fl.size() == 0)
        chk(1'b0, "R4", "unexpected flush", {fl_addr, fl_data}, 0);
      else begin
        logic [ADDR_W+LINE_W-1:0] e;
        string t;
        e = exp_fl.pop_front();
        t = fl_tag.pop_front();
        chk({fl_addr, fl_data} == e, t, "flush {addr,data}", {fl_addr, fl_data}, e);
      end
    end
  end

  // L1 responder: returns data after a fetching command
  always @(negedge clk) begin
    if (rst_n && dn_valid && dn_ready && dn_fetch) begin
      logic [ADDR_W-1:0] a;
      a = dn_addr;
      @(posedge clk);
      #1;
      rt_valid = 1'b1;
      rt_data  = l1val(a);
      forever begin
        @(negedge clk);
        if (rt_ready) break;
      end
      @(posedge clk);
      #1;
      rt_valid = 1'b0;
    end
  end

  task automatic up_send(logic [1:0] op, logic [ADDR_W-1:0] a, bit wr, bit excl,
                         bit dirty, logic [LINE_W-1:0] d);
    @(posedge clk);
    #1;
    up_valid = 1'b1; up_op = op; up_addr = a;
    up_wr = wr; up_excl = excl; up_dirty = dirty; up_data = d;
    do @(negedge clk); while (!up_ready);
    @(posedge clk);
    #1;
    up_valid = 1'b0;
  endtask

  task automatic fill(logic [ADDR_W-1:0] a, bit wr, bit excl);
    up_send(2'd0, a, wr, excl, 1'b0, memval(a));
  endtask

  task automatic snoop(bit rdx, logic [ADDR_W-1:0] a);
    @(posedge clk);
    #1;
    snp_valid = 1'b1; snp_rdx = rdx; snp_addr = a;
    do @(negedge clk); while (!snp_ready);
    @(posedge clk);
    #1;
    snp_valid = 1'b0;
  endtask

  task automatic settle(string req);
    repeat (60) @(posedge clk);
    chk(exp_dn.size() == 0 && exp_fl.size() == 0, req, "expected items still pending",
        {exp_dn.size(), exp_fl.size()}, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(up_ready && snp_ready && !dn_valid && !fl_valid, "R1", "ready/valid after reset",
        {up_ready, snp_ready, dn_valid, fl_valid}, 4'b1100);
    // R1/R4 snoops to an empty cache stay quiet
    snoop(1'b0, 12'h010);
    snoop(1'b1, 12'h010);
    settle("R4");

    // R2/R7/R3: exclusive fill, read snoop downgrades, RdX invalidates
    fill(12'h021, 1'b0, 1'b1);
    want_dn(12'h021, 1'b0, 1'b0, "R7");
    snoop(1'b0, 12'h021);
    want_dn(12'h021, 1'b1, 1'b0, "R3");
    snoop(1'b1, 12'h021);
    snoop(1'b0, 12'h021);          // R3: now invalid, nothing happens
    settle("R3");

    // R2/R7: write fill is Modified, read snoop flushes memory data
    fill(12'h032, 1'b1, 1'b0);
    want_dn(12'h032, 1'b0, 1'b0, "R7");
    want_fl(12'h032, memval(12'h032), "R7");
    snoop(1'b0, 12'h032);
    snoop(1'b0, 12'h032);          // R7: Shared, nothing
    settle("R7");

    // R5/R6: write hit makes stale; read snoop fetches then flushes L1 data
    fill(12'h043, 1'b0, 1'b1);
    up_send(2'd1, 12'h043, 1'b0, 1'b0, 1'b0, '0);
    want_dn(12'h043, 1'b0, 1'b1, "R6");
    want_fl(12'h043, l1val(12'h043), "R6");
    snoop(1'b0, 12'h043);
    snoop(1'b0, 12'h043);          // R6: clean Shared afterwards
    want_dn(12'h043, 1'b1, 1'b0, "R3");
    snoop(1'b1, 12'h043);
    settle("R6");

    // R5: write hit to Shared or absent line is ignored
    fill(12'h054, 1'b0, 1'b0);
    up_send(2'd1, 12'h054, 1'b0, 1'b0, 1'b0, '0);
    snoop(1'b0, 12'h054);
    up_send(2'd1, 12'h065, 1'b0, 1'b0, 1'b0, '0);
    snoop(1'b0, 12'h065);
    settle("R5");

    // R8: RdX on stale Modified fetches, invalidates and flushes
    fill(12'h076, 1'b0, 1'b1);
    up_send(2'd1, 12'h076, 1'b0, 1'b0, 1'b0, '0);
    want_dn(12'h076, 1'b1, 1'b1, "R8");
    want_fl(12'h076, l1val(12'h076), "R8");
    snoop(1'b1, 12'h076);
    snoop(1'b0, 12'h076);
    settle("R8");

    // R9: dirty eviction updates data, clears flags; clean eviction clears in-L1
    fill(12'h087, 1'b1, 1'b0);
    up_send(2'd2, 12'h087, 1'b0, 1'b0, 1'b1, 32'hABCD_0087);
    want_fl(12'h087, 32'hABCD_0087, "R9");
    snoop(1'b0, 12'h087);
    fill(12'h090, 1'b0, 1'b1);
    up_send(2'd2, 12'h090, 1'b0, 1'b0, 1'b0, '0);
    snoop(1'b1, 12'h090);
    settle("R9");

    // R10: displacing fill of a stale victim, then of a clean shared victim
    fill(12'h0A1, 1'b0, 1'b1);
    up_send(2'd1, 12'h0A1, 1'b0, 1'b0, 1'b0, '0);
    want_dn(12'h0A1, 1'b1, 1'b1, "R10");
    want_fl(12'h0A1, l1val(12'h0A1), "R10");
    fill(12'h0B1, 1'b0, 1'b0);
    snoop(1'b0, 12'h0B1);
    snoop(1'b1, 12'h0A1);
    want_dn(12'h0B1, 1'b1, 1'b0, "R10");
    snoop(1'b1, 12'h0B1);
    want_dn(12'h032, 1'b1, 1'b0, "R10");
    fill(12'h0C2, 1'b0, 1'b0);
    settle("R10");

    // R11: snoop and write hit offered together; snoop goes first
    fill(12'h0D3, 1'b1, 1'b0);
    settle("R11");
    want_dn(12'h0D3, 1'b0, 1'b0, "R11");
    want_fl(12'h0D3, memval(12'h0D3), "R11");
    @(posedge clk);
    #1;
    snp_valid = 1'b1; snp_rdx = 1'b0; snp_addr = 12'h0D3;
    up_valid = 1'b1; up_op = 2'd1; up_addr = 12'h0D3;
    up_wr = 1'b0; up_excl = 1'b0; up_dirty = 1'b0;
    @(negedge clk);
    chk(snp_ready && !up_ready, "R11", "snoop preferred", {snp_ready, up_ready}, 2'b10);
    @(posedge clk);
    #1;
    snp_valid = 1'b0;
    do @(negedge clk); while (!up_ready);
    @(posedge clk);
    #1;
    up_valid = 1'b0;
    snoop(1'b0, 12'h0D3);
    settle("R11");

    // R12: flush held while the bus is not ready
    fill(12'h0E5, 1'b1, 1'b0);
    hold_fl = 1'b1;
    want_dn(12'h0E5, 1'b0, 1'b0, "R12");
    want_fl(12'h0E5, memval(12'h0E5), "R12");
    snoop(1'b0, 12'h0E5);
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(fl_valid && fl_addr == 12'h0E5, "R12", "flush pending under stall",
        {fl_valid, fl_addr}, {1'b1, 12'h0E5});
    chk(!snp_ready && !up_ready, "R12", "ports blocked while busy",
        {snp_ready, up_ready}, 2'b00);
    hold_fl = 1'b0;
    settle("R12");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule